// File: doc/BRIEF.md
# Eight-Operand Carry-Save Summation Tree

This block adds eight unsigned N-bit operands that arrive together on one wide input bus. A load strobe copies all eight operands into an input bank. They are then zero-extended to the output width and reduced by four layers of bitwise 3:2 compressors. Each compressor column turns three bits into a sum bit (the XOR of the three) and a carry bit (their majority). No column depends on any other column, so the depth of a layer does not grow with N.

The carry vector of each compressor counts at twice the weight, so it is shifted one place left before it feeds the next layer. Operands that do not fit into a group of three pass to the next layer unchanged. This continues until two vectors remain. One carry-propagate adder then resolves that redundant pair into a plain binary sum of N+3 bits, which no eight N-bit values can overflow. The sum is held in an output register.

When the pair-exposure parameter is set, the registered final sum and carry vectors of the tree are also driven out, so that the redundant form can be checked against the resolved result.

Top module: `opsum_top`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `outValid` is 0 and `sumOut`, `pairSum` and `pairCarry` are all zero.
- R2: Operands presented with `inValid` high at a rising edge produce their result in `sumOut` at the second rising edge after it. `outValid` is high for exactly one cycle per load. Loads on consecutive cycles produce results on consecutive cycles.
- R3: `sumOut` equals the exact arithmetic sum of the eight loaded operands, in N+3 bits. For all-ones operands it is 8*(2^N-1), and it never exceeds that value.
- R4: While `inValid` is low, operand changes have no effect: `sumOut`, `pairSum` and `pairCarry` keep their last values and `outValid` stays 0.
- R5: Operand k (k = 0..7) occupies bits [k*N +: N] of `opsFlat`, and every lane counts with equal weight.
- R6: With SHOW_PAIR=1, `pairSum + pairCarry` taken modulo 2^(N+3) equals `sumOut` whenever `outValid` is high. With SHOW_PAIR=0, both pair outputs are constantly zero.
- R7: `pairCarry` is the already-shifted carry vector, so its bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Load strobe for the input bank |
| opsFlat | input | 8*N | Eight packed operands, lane k at bits [k*N +: N] |
| outValid | output | 1 | High for one cycle when a new sum is in `sumOut` |
| sumOut | output | N+3 | Registered binary sum of the eight operands |
| pairSum | output | N+3 | Registered final sum vector of the tree (zero when SHOW_PAIR=0) |
| pairCarry | output | N+3 | Registered final carry vector, already shifted left by one (zero when SHOW_PAIR=0) |

## Verification
The bench builds the block with N=4 and SHOW_PAIR=1. This gives a 32-bit operand bus and a 7-bit result.

At that width every value of every lane can be swept alone, which pins each lane's position and weight. The all-ones maximum of 120 is reachable directly, and so is every intermediate carry pattern of the tree. Random and streaming loads then cover mixed carries and back-to-back timing, and the exposed redundant pair is checked against the resolved sum.

// File: rtl/opsum_pkg.sv
package opsum_pkg;
  localparam int OPS = 8;
  localparam int EXTRA = 3;

  typedef struct packed {
    logic bankLoad;
    logic outLoad;
  } strobe_t;
endpackage

// File: rtl/opsum_csa.sv
module opsum_csa #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  for (genvar i = 0; i < W; i++) begin : g_col
    assign s[i] = x[i] ^ y[i] ^ z[i];
    assign c[i] = (x[i] & y[i]) | (y[i] & z[i]) | (z[i] & x[i]);
  end
endmodule

// File: rtl/opsum_ctrl.sv
module opsum_ctrl
  import opsum_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strb,
  output logic    outValid
);
  logic bankFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankFull <= 1'b0;
      outValid <= 1'b0;
    end else begin
      bankFull <= inValid;
      outValid <= bankFull;
    end
  end

  always_comb begin
    strb.bankLoad = inValid;
    strb.outLoad  = bankFull;
  end
endmodule

// File: rtl/opsum_dp.sv
module opsum_dp
  import opsum_pkg::*;
#(
  parameter int N = 16,
  parameter bit SHOW_PAIR = 1'b1,
  localparam int W = N + EXTRA
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strb,
  input  logic [OPS*N-1:0] opsFlat,
  output logic [W-1:0]   sumOut,
  output logic [W-1:0]   pairSum,
  output logic [W-1:0]   pairCarry
);
  logic [N-1:0] bank [OPS];
  logic [W-1:0] ext  [OPS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < OPS; k++) bank[k] <= '0;
    end else if (strb.bankLoad) begin
      for (int k = 0; k < OPS; k++) bank[k] <= opsFlat[k*N +: N];
    end
  end

  for (genvar k = 0; k < OPS; k++) begin : g_ext
    assign ext[k] = W'(bank[k]);
  end

  // layer 1: 8 -> 6
  logic [W-1:0] s1a, c1a, s1b, c1b, c1aSh, c1bSh;
  opsum_csa #(.W(W)) u_l1a (.x(ext[0]), .y(ext[1]), .z(ext[2]), .s(s1a), .c(c1a));
  opsum_csa #(.W(W)) u_l1b (.x(ext[3]), .y(ext[4]), .z(ext[5]), .s(s1b), .c(c1b));
  assign c1aSh = c1a << 1;
  assign c1bSh = c1b << 1;

  // layer 2: 6 -> 4
  logic [W-1:0] s2a, c2a, s2b, c2b, c2aSh, c2bSh;
  opsum_csa #(.W(W)) u_l2a (.x(s1a), .y(c1aSh), .z(s1b), .s(s2a), .c(c2a));
  opsum_csa #(.W(W)) u_l2b (.x(c1bSh), .y(ext[6]), .z(ext[7]), .s(s2b), .c(c2b));
  assign c2aSh = c2a << 1;
  assign c2bSh = c2b << 1;

  // layer 3: 4 -> 3, c2bSh passes through
  logic [W-1:0] s3, c3, c3Sh;
  opsum_csa #(.W(W)) u_l3 (.x(s2a), .y(c2aSh), .z(s2b), .s(s3), .c(c3));
  assign c3Sh = c3 << 1;

  // layer 4: 3 -> 2
  logic [W-1:0] s4, c4, finSum, finCarry, resolved;
  opsum_csa #(.W(W)) u_l4 (.x(s3), .y(c3Sh), .z(c2bSh), .s(s4), .c(c4));
  assign finSum   = s4;
  assign finCarry = c4 << 1;

  // single carry-propagate adder
  assign resolved = finSum + finCarry;

  always_ff @(posedge clk) begin
    if (!rstN)             sumOut <= '0;
    else if (strb.outLoad) sumOut <= resolved;
  end

  if (SHOW_PAIR) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pairSum   <= '0;
        pairCarry <= '0;
      end else if (strb.outLoad) begin
        pairSum   <= finSum;
        pairCarry <= finCarry;
      end
    end
  end else begin : g_nopair
    assign pairSum   = '0;
    assign pairCarry = '0;
  end
endmodule

// File: rtl/opsum_top.sv
module opsum_top
  import opsum_pkg::*;
#(
  parameter int N = 16,
  parameter bit SHOW_PAIR = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [8*N-1:0]     opsFlat,
  output logic               outValid,
  output logic [N+2:0]       sumOut,
  output logic [N+2:0]       pairSum,
  output logic [N+2:0]       pairCarry
);
  strobe_t strb;

  opsum_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb), .outValid(outValid)
  );

  opsum_dp #(.N(N), .SHOW_PAIR(SHOW_PAIR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opsFlat(opsFlat),
    .sumOut(sumOut), .pairSum(pairSum), .pairCarry(pairCarry)
  );
endmodule

// File: rtl/opsum_chk.sv
module opsum_chk #(
  parameter int N = 16,
  parameter bit SHOW_PAIR = 1'b1,
  localparam int W = N + 3
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         outValid,
  input logic [W-1:0] sumOut,
  input logic [W-1:0] pairSum,
  input logic [W-1:0] pairCarry
);
  localparam logic [W-1:0] MAXV = {{N{1'b1}}, 3'b000};

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!outValid && sumOut == '0 && pairSum == '0 && pairCarry == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (sumOut <= MAXV));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(sumOut) && $stable(pairSum) && $stable(pairCarry)));

  p_pair_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (!SHOW_PAIR || (W'(pairSum + pairCarry) == sumOut)));

  p_carry_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pairCarry[0] == 1'b0));
endmodule

bind opsum_top opsum_chk #(.N(N), .SHOW_PAIR(SHOW_PAIR)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .sumOut(sumOut), .pairSum(pairSum), .pairCarry(pairCarry)
);

// File: tb/opsum_top_bench.sv
`timescale 1ns/1ps
module opsum_top_bench;
  localparam int N = 4;
  localparam int W = N + 3;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           inValid = 1'b0;
  logic [8*N-1:0] opsFlat = '0;
  logic           outValid;
  logic [W-1:0]   sumOut, pairSum, pairCarry;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  opsum_top #(.N(N), .SHOW_PAIR(1'b1)) u_opsum_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opsFlat(opsFlat),
    .outValid(outValid), .sumOut(sumOut), .pairSum(pairSum), .pairCarry(pairCarry)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int refSum(input logic [8*N-1:0] f);
    int t = 0;
    for (int k = 0; k < 8; k++) t += int'(f[k*N +: N]);
    return t;
  endfunction

  task automatic checkPair(input string tag);
    check({tag, " R6 pair"}, int'(W'(pairSum + pairCarry)), int'(sumOut));
    check({tag, " R7 carry lsb"}, int'(pairCarry[0]), 0);
  endtask

  task automatic runOne(input logic [8*N-1:0] f, input string tag);
    @(negedge clk);
    opsFlat = f; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check({tag, " R2 valid"}, int'(outValid), 1);
    check({tag, " R3 sum"}, int'(sumOut), refSum(f));
    checkPair(tag);
  endtask

  initial begin
    logic [8*N-1:0] f;
    logic [W-1:0] held;
    int exps [40];
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(outValid), 0);
    check("R1 sum in reset", int'(sumOut), 0);
    check("R1 pair in reset", int'(pairSum | pairCarry), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(outValid), 0);
    check("R1 sum after reset", int'(sumOut), 0);

    // R5: each lane alone, every value
    for (int k = 0; k < 8; k++) begin
      for (int v = 0; v < (1 << N); v++) begin
        f = '0;
        f[k*N +: N] = N'(v);
        runOne(f, $sformatf("R5 lane%0d v%0d", k, v));
      end
    end

    // R3 corner cases
    runOne('0, "R3 all-zero");
    runOne('1, "R3 all-ones");
    check("R3 max value", int'(sumOut), 8 * ((1 << N) - 1));
    runOne(32'hF0F0_F0F0, "R3 alt lanes");
    runOne(32'h1111_1111, "R3 all one");

    // R2: one-cycle pulse, then R4 hold while inputs change
    held = sumOut;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      opsFlat = $urandom();
      check("R2 pulse once", int'(outValid), 0);
      check("R4 sum held", int'(sumOut), int'(held));
      checkPair("R4 held");
    end

    // R3 random loads
    for (int i = 0; i < 400; i++) runOne($urandom(), "R3 random");

    // R2 back-to-back streaming
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R2 stream valid", int'(outValid), 1);
        check("R2 stream sum", int'(sumOut), exps[j-2]);
      end
      f = (j % 5 == 0) ? '1 : $urandom();
      exps[j] = refSum(f);
      opsFlat = f; inValid = 1'b1;
    end
    for (int j = 40; j < 42; j++) begin
      @(negedge clk);
      inValid = 1'b0;
      check("R2 stream drain valid", int'(outValid), 1);
      check("R2 stream drain sum", int'(sumOut), exps[j-2]);
    end
    @(negedge clk);
    check("R2 stream end", int'(outValid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule